// File: doc/BRIEF.md
# Line Brown-out Supervisor with Zero-Cross Shutdown

This block decides whether a single-stage offline converter may keep switching, based on three digital observations of the rectified line: a flag that is high while the line sits above a start level, a flag that is high while the line sits below a lower stop level, and a one-cycle pulse marking each line zero crossing. The analogue sensing and the two comparator levels, nominally 111 V to start and 96 V to stop, live outside the block. The gap between the two levels gives the hysteresis.

After reset the run permit stays low until the line is seen above the start level. While running, the block qualifies a sag: the line must stay below the stop level for an unbroken window of `BLANK_CYCLES` clocks (about 54 ms in a real system) before a shutdown flag is latched. Latching the flag does not stop switching at once. The permit is held until the next zero crossing, so that the stage stops while little energy is stored in the input filter. Once it has stopped, switching stays suspended until the line climbs back over the start level. A bypass input forces the permit high for builds where brown-out supervision is not wanted.

Top module: `line_brownout_sup`

## Requirements
- R1: After reset `run_permit_o` is 0, and it stays 0 for as long as `line_above_start_i` is 0 (with `bypass_i` at 0), whatever the other inputs do.
- R2: From the stopped condition, a cycle sampled with `line_above_start_i`=1 makes `run_permit_o` 1 from the following cycle.
- R3: While running, `BLANK_CYCLES` consecutive samples with `line_below_stop_i`=1 latch the shutdown flag, and `run_permit_o` stays 1 after the flag is latched.
- R4: Any sample with `line_below_stop_i`=0 during the qualification window restarts the count from zero, so a sag of `BLANK_CYCLES`-1 samples never latches the flag.
- R5: With the flag latched, a sample with `zero_cross_i`=1 and `line_above_start_i`=0 makes `run_permit_o` 0 from the next cycle.
- R6: A `zero_cross_i` pulse while running with no flag latched has no effect on `run_permit_o`.
- R7: After a zero-cross stop, `run_permit_o` stays 0 even once `line_below_stop_i` returns to 0, until `line_above_start_i` is sampled at 1.
- R8: With the flag latched, `line_above_start_i`=1 clears the flag and running continues, and it takes priority over a `zero_cross_i` in the same cycle.
- R9: `bypass_i`=1 drives `run_permit_o` to 1 in the same cycle, without a register. The supervision state keeps evolving underneath and reappears when `bypass_i` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| line_above_start_i | input | 1 | Line is above the start level |
| line_below_stop_i | input | 1 | Line is below the stop level |
| zero_cross_i | input | 1 | One-cycle pulse at a line zero crossing |
| bypass_i | input | 1 | Forces the run permit high |
| run_permit_o | output | 1 | Switching allowed |

## Verification
The bench targets the sag window one sample short of and exactly at `BLANK_CYCLES`. A count that is off by one would latch the flag early or late, and a counter that only pauses on a one-cycle rise above the stop level, rather than clearing, would latch a sag that is really broken. It places zero crossings both before and after the flag is latched. A design that cuts switching when the flag latches, or on any zero crossing, would drop the permit too early. It also drives start and zero crossing in the same cycle and releases the stop flag with no start seen. A wrong priority or an auto-restart would then show up as a permit that is wrongly low or wrongly high.

// File: rtl/line_brownout_pkg.sv
package line_brownout_pkg;

  typedef enum logic [1:0] {
    BO_IDLE  = 2'd0,
    BO_RUN   = 2'd1,
    BO_DRAIN = 2'd2
  } bo_state_e;

  // True when the sag count has reached the last cycle of the window.
  function automatic logic window_last(input int unsigned count, input int unsigned window);
    return (count + 1) >= window;
  endfunction

  // A state in which the power stage may switch.
  function automatic logic state_runs(input bo_state_e st);
    return (st == BO_RUN) || (st == BO_DRAIN);
  endfunction

endpackage

// File: rtl/bo_sag_qualifier.sv
module bo_sag_qualifier
  import line_brownout_pkg::*;
#(
  parameter int unsigned BLANK_CYCLES = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic below_stop_i,
  output logic sag_qualified_o
);

  localparam int unsigned CNT_W = (BLANK_CYCLES > 1) ? $clog2(BLANK_CYCLES) : 1;

  logic [CNT_W-1:0] sag_cnt_q;
  logic             sag_active;
  logic             sag_restart;

  assign sag_active      = enable_i && below_stop_i;
  assign sag_restart     = !sag_active;
  assign sag_qualified_o = sag_active && window_last(32'(sag_cnt_q), BLANK_CYCLES);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      sag_cnt_q <= '0;
    end else if (sag_restart || sag_qualified_o) begin
      sag_cnt_q <= '0;
    end else begin
      sag_cnt_q <= sag_cnt_q + 1'b1;
    end
  end

  // R4: a break in the sag clears the count by the next cycle
  assert_sag_restart_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && !below_stop_i) |=> (sag_cnt_q == '0));

  // R4: the count only climbs one step at a time while the sag persists
  assert_sag_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sag_active && !sag_qualified_o) |=> (32'(sag_cnt_q) == 32'($past(sag_cnt_q)) + 1));

endmodule

// File: rtl/bo_permit_fsm.sv
module bo_permit_fsm
  import line_brownout_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      above_start_i,
  input  logic      zero_cross_i,
  input  logic      sag_qualified_i,
  output bo_state_e state_o,
  output logic      qualify_en_o
);

  bo_state_e state_q, state_d;
  logic      start_seen;
  logic      drain_stop;

  assign start_seen = above_start_i;
  assign drain_stop = (state_q == BO_DRAIN) && !above_start_i && zero_cross_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      BO_IDLE:  if (start_seen) state_d = BO_RUN;
      BO_RUN:   if (sag_qualified_i) state_d = BO_DRAIN;
      BO_DRAIN: begin
        if (start_seen)      state_d = BO_RUN;
        else if (drain_stop) state_d = BO_IDLE;
      end
      default:  state_d = BO_IDLE;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) state_q <= BO_IDLE;
    else         state_q <= state_d;
  end

  assign state_o      = state_q;
  assign qualify_en_o = (state_q == BO_RUN);

  // R1/R7: stopped stays stopped without the start flag
  assert_idle_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == BO_IDLE && !above_start_i) |=> (state_q == BO_IDLE));

  // R3: the flag is latched only from running after a qualified sag
  assert_drain_entry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == BO_RUN && sag_qualified_i) |=> (state_q == BO_DRAIN));

  // R5: with the flag latched, switching continues until a zero crossing
  assert_drain_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == BO_DRAIN && !zero_cross_i && !above_start_i) |=> (state_q == BO_DRAIN));

  // R5: a zero crossing with the flag latched stops switching
  assert_zc_stop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == BO_DRAIN && zero_cross_i && !above_start_i) |=> (state_q == BO_IDLE));

  // R8: start wins over a zero crossing while draining
  assert_start_priority_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == BO_DRAIN && above_start_i) |=> (state_q == BO_RUN));

  // R6: a zero crossing without the flag never stops switching
  assert_zc_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == BO_RUN && !sag_qualified_i) |=> (state_q == BO_RUN));

endmodule

// File: rtl/line_brownout_sup.sv
module line_brownout_sup
  import line_brownout_pkg::*;
#(
  parameter int unsigned BLANK_CYCLES = 10_800_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_above_start_i,
  input  logic line_below_stop_i,
  input  logic zero_cross_i,
  input  logic bypass_i,
  output logic run_permit_o
);

  bo_state_e sup_state;
  logic      qualify_en;
  logic      sag_qualified;
  logic      stage_runs;

  bo_sag_qualifier #(.BLANK_CYCLES(BLANK_CYCLES)) sag_i (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .enable_i        (qualify_en),
    .below_stop_i    (line_below_stop_i),
    .sag_qualified_o (sag_qualified)
  );

  bo_permit_fsm fsm_i (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .above_start_i   (line_above_start_i),
    .zero_cross_i    (zero_cross_i),
    .sag_qualified_i (sag_qualified),
    .state_o         (sup_state),
    .qualify_en_o    (qualify_en)
  );

  assign stage_runs   = state_runs(sup_state);
  assign run_permit_o = bypass_i || stage_runs;

  // R9: bypass forces the permit in the same cycle
  always_comb begin
    if (rst_ni && bypass_i) assert_bypass_R9: assert (run_permit_o);
  end

  // R2: start from idle grants the permit the cycle after
  assert_start_grant_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stage_runs && line_above_start_i) |=> stage_runs);

endmodule

// File: tb/line_brownout_sup_tb_top.sv
`timescale 1ns/1ps
module line_brownout_sup_tb_top;

  localparam int unsigned BLANK = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic above = 1'b0, below = 1'b0, zc = 1'b0, byp = 1'b0;
  logic permit;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference model: 0 stopped, 1 running, 2 running with flag latched
  int m_mode = 0;
  int m_low  = 0;

  always #2.5 clk = ~clk;

  line_brownout_sup #(.BLANK_CYCLES(BLANK)) dut_i (
    .clk_i              (clk),
    .rst_ni             (rst_n),
    .line_above_start_i (above),
    .line_below_stop_i  (below),
    .zero_cross_i       (zc),
    .bypass_i           (byp),
    .run_permit_o       (permit)
  );

  function automatic logic expect_permit(input int mode, input logic b);
    return b || (mode != 0);
  endfunction

  task automatic model_edge();
    if (!rst_n) begin
      m_mode = 0; m_low = 0;
    end else if (m_mode == 0) begin
      if (above) begin m_mode = 1; m_low = 0; end
    end else if (m_mode == 1) begin
      if (below) m_low++;
      else       m_low = 0;
      if (m_low >= BLANK) begin m_mode = 2; m_low = 0; end
    end else begin
      if (above)   begin m_mode = 1; m_low = 0; end
      else if (zc) m_mode = 0;
    end
  endtask

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: run_permit_o=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // Drive after the falling edge, check against the model, then advance it.
  task automatic step(input logic a, input logic b, input logic z, input logic y, input string req);
    @(negedge clk);
    above = a; below = b; zc = z; byp = y;
    #1;
    check(permit, expect_permit(m_mode, y), req);
    model_edge();
  endtask

  task automatic lit(input logic exp, input string req);
    #0.5;
    check(permit, exp, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    step(0, 0, 0, 0, "R1 reset");
    step(0, 0, 0, 0, "R1 reset");
    lit(1'b0, "R1 reset");
    rst_n = 1'b1;
    // R1: idle stays low under sag and zero crossings
    for (int i = 0; i < 30; i++) step(0, 1, i[0], 0, "R1 idle hold");
    lit(1'b0, "R1 idle hold");
    // R2: start grants
    step(1, 0, 0, 0, "R2 start");
    step(0, 0, 0, 0, "R2 start");
    lit(1'b1, "R2 start");
    // R4: sags one short of the window, broken by a single high sample
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < BLANK - 1; i++) step(0, 1, 0, 0, "R4 short sag");
      step(0, 0, 0, 0, "R4 short sag");
    end
    // R6: zero cross while running without the flag
    step(0, 0, 1, 0, "R6 zc ignored");
    step(0, 0, 0, 0, "R6 zc ignored");
    lit(1'b1, "R6 zc ignored");
    // R3: full window latches the flag but permit remains
    for (int i = 0; i < BLANK; i++) step(0, 1, 0, 0, "R3 full sag");
    for (int i = 0; i < 5; i++) step(0, 1, 0, 0, "R3 drain");
    lit(1'b1, "R3 drain");
    // R5: zero cross ends switching
    step(0, 1, 1, 0, "R5 zc stop");
    step(0, 1, 0, 0, "R5 zc stop");
    lit(1'b0, "R5 zc stop");
    // R7: stop flag clears but no start: stays low
    for (int i = 0; i < 10; i++) step(0, 0, 0, 0, "R7 hold low");
    lit(1'b0, "R7 hold low");
    // R9: bypass forces high in the same cycle, state unchanged underneath
    step(0, 0, 0, 1, "R9 bypass");
    lit(1'b1, "R9 bypass");
    step(0, 0, 0, 0, "R9 bypass release");
    lit(1'b0, "R9 bypass release");
    // R8: start and zero cross together while flag latched
    step(1, 0, 0, 0, "R8 setup");
    for (int i = 0; i < BLANK; i++) step(0, 1, 0, 0, "R8 setup");
    step(1, 1, 1, 0, "R8 priority");
    step(0, 0, 1, 0, "R8 priority");
    step(0, 0, 0, 0, "R8 priority");
    lit(1'b1, "R8 priority");
    // random mix, checked against the model each cycle
    for (int i = 0; i < 6000; i++) begin
      logic a, b, z, y;
      a = ($urandom_range(0, 99) < 3);
      b = ($urandom_range(0, 99) < 93);
      z = ($urandom_range(0, 99) < 4);
      y = ($urandom_range(0, 99) < 2);
      step(a, b, z, y, "R3 R5 random");
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule